// File: doc/BRIEF.md
# Chained Product-Term Macrocell Array

This block is a small programmable logic slice of nine macrocells. Each macrocell takes four local product-term signals and one set/reset term, ORs them into a sum, and presents that sum either straight through or through a register that behaves as a D or a T flip-flop. The output can be inverted. Product terms are computed upstream; this block only steers, ORs and registers them.

For functions wider than four terms, a macrocell can hand its whole group of terms to the next macrocell up the chain, which merges them with its own. A cell that gets terms this way stops using its set/reset term for set/reset and adds it to its sum instead. Chaining all nine cells gives one output that covers all 36 local terms. Per-cell configuration sits in registers written through a simple address/data port, and a synchronous reset returns every cell to its default.

Top module: `pterm_chain_array`

## Requirements
- R1: While `srst` is high at a clock edge, all configuration words and all macrocell registers clear to 0 (no export, D mode, true polarity, registered output, set/reset acts as reset), so every bit of `mcOut` is 0 in the cycle after that edge.
- R2: With `cfgWe` high at an edge and `cfgAddr` below 9, the word on `cfgData` is stored for cell `cfgAddr`. Its bits are: bit 0 export, bit 1 toggle (T) mode, bit 2 invert, bit 3 bypass, bit 4 set-kind. Writes to addresses 9 to 15 change nothing.
- R3: Cell i uses `ptIn[5i+3:5i]` as its local terms and `ptIn[5i+4]` as its set/reset term. A cell that neither exports nor receives has a sum equal to the OR of its four local terms.
- R4: An exporting cell passes its gathered sum (its own terms plus any incoming chain) to cell i+1, and its own OR gate sees constant 0.
- R5: A cell whose lower neighbour exports ORs its set/reset term into its sum, and that term then neither sets nor clears its register.
- R6: With cells 0 to 7 exporting, the sum of cell 8 is the OR of all 36 local terms and the set/reset terms of cells 1 to 8.
- R7: The export bit of cell 8 has no effect.
- R8: In D mode, with no active set/reset, the register loads the sum at each edge.
- R9: In T mode, with no active set/reset, the register inverts at each edge where the sum is 1 and holds otherwise.
- R10: A high set/reset term on a cell that does not receive forces its register at the next edge to 1 if set-kind is 1, or to 0 if set-kind is 0, in either mode.
- R11: With the invert bit set, the cell output is the complement of the selected value.
- R12: With bypass set the cell output follows the sum combinationally; with bypass clear it follows the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 4 | Cell index of the configuration write |
| cfgData | input | 5 | Configuration word for the addressed cell |
| ptIn | input | 45 | Product terms, five per cell (four local, one set/reset) |
| mcOut | output | 9 | Macrocell outputs |

## Verification
The register assertions assume the product-term inputs and configuration only change between edges, so the sum seen at an edge is the one computed from the stored configuration before that edge; the bench drives all inputs on the falling edge to keep it so. The configuration-hold check assumes any write to an out-of-range address is filtered before it reaches the storage, which the bench probes by writing all-ones to every unused address and then confirming the outputs still match the unchanged model. Sweeps walk single terms through the full chain and step through every local-term value per cell, while random phases mix exports, modes and set/reset terms.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

  // Per-cell configuration word; bit order is the write-port encoding.
  typedef struct packed {
    logic setKind;   // bit 4: set/reset term sets (1) or clears (0)
    logic bypass;    // bit 3: combinational output
    logic invert;    // bit 2: output inverted
    logic toggle;    // bit 1: T mode
    logic exportEn;  // bit 0: pass terms to the next cell
  } cellCfg_t;

  localparam int CfgW = $bits(cellCfg_t);
  localparam int StrobeIdxW = 8;

  // Write strobe from control to datapath.
  typedef struct packed {
    logic                  wrEn;
    logic [StrobeIdxW-1:0] wrIdx;
    cellCfg_t              wrData;
  } cfgStrobe_t;

endpackage

// File: rtl/pterm_ctrl.sv
module pterm_ctrl
  import pterm_pkg::*;
#(
  parameter int NumCells = 9,
  localparam int AddrW = $clog2(NumCells)
) (
  input  logic             cfgWe,
  input  logic [AddrW-1:0] cfgAddr,
  input  logic [CfgW-1:0]  cfgData,
  output cfgStrobe_t       stb
);

  logic addrValid;

  always_comb begin
    addrValid  = int'(cfgAddr) < NumCells;
    stb.wrEn   = cfgWe && addrValid;
    stb.wrIdx  = StrobeIdxW'(cfgAddr);
    stb.wrData = cellCfg_t'(cfgData);
  end

endmodule

// File: rtl/pterm_cell.sv
module pterm_cell
  import pterm_pkg::*;
#(
  parameter int LocalPts = 4,
  parameter bit IsLast   = 1'b0
) (
  input  logic                clk,
  input  logic                srst,
  input  cellCfg_t            cfg,
  input  logic [LocalPts-1:0] localPt,
  input  logic                srPt,
  input  logic                recvIn,
  input  logic                chainIn,
  output logic                exportOut,
  output logic                chainOut,
  output logic                cellOut
);

  logic gathered;
  logic sumOr;
  logic srActive;
  logic q;

  always_comb begin
    // Set/reset term joins the sum only when terms arrive from below.
    gathered  = (|localPt) | (recvIn & srPt) | chainIn;
    exportOut = cfg.exportEn && !IsLast;
    sumOr     = exportOut ? 1'b0 : gathered;
    chainOut  = exportOut ? gathered : 1'b0;
    srActive  = srPt && !recvIn;
    cellOut   = (cfg.bypass ? sumOr : q) ^ cfg.invert;
  end

  always_ff @(posedge clk) begin
    if (srst)          q <= 1'b0;
    else if (srActive) q <= cfg.setKind;
    else if (cfg.toggle) q <= q ^ sumOr;
    else               q <= sumOr;
  end

  a_r8_d_capture: assert property (@(posedge clk) disable iff (srst)
    (!srActive && !cfg.toggle) |=> (q == $past(sumOr)));

  a_r9_t_toggle: assert property (@(posedge clk) disable iff (srst)
    (!srActive && cfg.toggle) |=> (q == ($past(q) ^ $past(sumOr))));

  a_r10_sync_clear: assert property (@(posedge clk) disable iff (srst)
    (srActive && !cfg.setKind) |=> !q);

  a_r10_sync_preset: assert property (@(posedge clk) disable iff (srst)
    (srActive && cfg.setKind) |=> q);

  a_r5_sr_absorbed: assert property (@(posedge clk) disable iff (srst)
    (recvIn && srPt) |-> (sumOr || chainOut));

  generate
    if (IsLast) begin : g_lastChk
      a_r7_last_no_forward: assert property (@(posedge clk) disable iff (srst)
        cfg.exportEn |-> (!chainOut && (sumOr == gathered)));
    end
  endgenerate

endmodule

// File: rtl/pterm_datapath.sv
module pterm_datapath
  import pterm_pkg::*;
#(
  parameter int NumCells = 9,
  parameter int LocalPts = 4,
  localparam int PtStride = LocalPts + 1,
  localparam int PtW = NumCells * PtStride
) (
  input  logic                clk,
  input  logic                srst,
  input  cfgStrobe_t          stb,
  input  logic [PtW-1:0]      ptIn,
  output logic [NumCells-1:0] mcOut
);

  cellCfg_t [NumCells-1:0] cfgReg;
  logic     [NumCells-1:0] exportVec;
  logic     [NumCells-1:0] chainVec;

  generate
    for (genvar i = 0; i < NumCells; i++) begin : g_cell
      logic recvIn;
      logic chainIn;

      always_ff @(posedge clk) begin
        if (srst) cfgReg[i] <= '0;
        else if (stb.wrEn && (int'(stb.wrIdx) == i)) cfgReg[i] <= stb.wrData;
      end

      if (i == 0) begin : g_head
        assign recvIn  = 1'b0;
        assign chainIn = 1'b0;
      end else begin : g_link
        assign recvIn  = exportVec[i-1];
        assign chainIn = chainVec[i-1];
      end

      pterm_cell #(
        .LocalPts(LocalPts),
        .IsLast  (i == NumCells - 1)
      ) cell_i (
        .clk      (clk),
        .srst     (srst),
        .cfg      (cfgReg[i]),
        .localPt  (ptIn[i*PtStride +: LocalPts]),
        .srPt     (ptIn[i*PtStride + LocalPts]),
        .recvIn   (recvIn),
        .chainIn  (chainIn),
        .exportOut(exportVec[i]),
        .chainOut (chainVec[i]),
        .cellOut  (mcOut[i])
      );
    end
  endgenerate

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (srst)
    !stb.wrEn |=> $stable(cfgReg));

  a_r1_clear_out: assert property (@(posedge clk)
    srst |=> (mcOut == '0));

  a_r7_chain_end_quiet: assert property (@(posedge clk) disable iff (srst)
    !(exportVec[NumCells-1] || chainVec[NumCells-1]));

endmodule

// File: rtl/pterm_chain_array.sv
module pterm_chain_array
  import pterm_pkg::*;
#(
  parameter int NumCells = 9,
  parameter int LocalPts = 4,
  localparam int AddrW = $clog2(NumCells),
  localparam int PtW = NumCells * (LocalPts + 1)
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                cfgWe,
  input  logic [AddrW-1:0]    cfgAddr,
  input  logic [CfgW-1:0]     cfgData,
  input  logic [PtW-1:0]      ptIn,
  output logic [NumCells-1:0] mcOut
);

  cfgStrobe_t stb;

  pterm_ctrl #(.NumCells(NumCells)) ctrl_i (
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .stb    (stb)
  );

  pterm_datapath #(.NumCells(NumCells), .LocalPts(LocalPts)) dp_i (
    .clk  (clk),
    .srst (srst),
    .stb  (stb),
    .ptIn (ptIn),
    .mcOut(mcOut)
  );

endmodule

// File: tb/pterm_chain_array_tb.sv
`timescale 1ns/1ps
module pterm_chain_array_tb_top;

  localparam int NC = 9;
  localparam int PW = 45;

  logic          clk = 1'b0;
  logic          srst = 1'b1;
  logic          cfgWe = 1'b0;
  logic [3:0]    cfgAddr = '0;
  logic [4:0]    cfgData = '0;
  logic [PW-1:0] ptIn = '0;
  logic [NC-1:0] mcOut;

  int vectors = 0;
  int miscompares = 0;

  logic [4:0]    cfgM [NC];
  logic [NC-1:0] qM;

  always #2 clk = ~clk;

  pterm_chain_array dut_i (
    .clk(clk), .srst(srst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .ptIn(ptIn), .mcOut(mcOut)
  );

  function automatic logic [NC-1:0] recvOf();
    logic [NC-1:0] r;
    for (int i = 0; i < NC; i++) r[i] = (i > 0) && cfgM[i-1][0];
    return r;
  endfunction

  function automatic logic [NC-1:0] sumsOf(input logic [PW-1:0] pt);
    logic [NC-1:0] s;
    logic [NC-1:0] rv;
    logic carry;
    logic acc;
    logic ex;
    rv = recvOf();
    carry = 1'b0;
    for (int i = 0; i < NC; i++) begin
      acc = (|pt[5*i +: 4]) | (rv[i] & pt[5*i+4]) | carry;
      ex  = cfgM[i][0] && (i < NC - 1);
      s[i]  = ex ? 1'b0 : acc;
      carry = ex ? acc : 1'b0;
    end
    return s;
  endfunction

  function automatic logic [NC-1:0] expOut(input logic [PW-1:0] pt);
    logic [NC-1:0] s;
    logic [NC-1:0] o;
    s = sumsOf(pt);
    for (int i = 0; i < NC; i++) o[i] = (cfgM[i][3] ? s[i] : qM[i]) ^ cfgM[i][2];
    return o;
  endfunction

  function automatic logic [PW-1:0] rnd();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] srMask();
    logic [PW-1:0] m;
    m = '0;
    for (int i = 0; i < NC; i++) m[5*i+4] = 1'b1;
    return m;
  endfunction

  task automatic applyCycle(input string tag, input logic rst, input logic we,
                            input logic [3:0] addr, input logic [4:0] data,
                            input logic [PW-1:0] pt);
    logic [NC-1:0] e;
    logic [NC-1:0] s;
    logic [NC-1:0] rv;
    @(negedge clk);
    srst = rst; cfgWe = we; cfgAddr = addr; cfgData = data; ptIn = pt;
    #1;
    e = expOut(pt);
    vectors++;
    if (mcOut !== e) begin
      miscompares++;
      $display("FAIL %s: mcOut=%b expected %b", tag, mcOut, e);
    end
    s = sumsOf(pt);
    rv = recvOf();
    @(posedge clk);
    if (rst) begin
      qM = '0;
      for (int i = 0; i < NC; i++) cfgM[i] = '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (pt[5*i+4] && !rv[i]) qM[i] = cfgM[i][4];
        else if (cfgM[i][1])     qM[i] = qM[i] ^ s[i];
        else                     qM[i] = s[i];
      end
      if (we && addr < NC) cfgM[addr] = data;
    end
  endtask

  task automatic writeAll(input logic [4:0] data);
    for (int a = 0; a < NC; a++) applyCycle("R2", 1'b0, 1'b1, 4'(a), data, rnd());
  endtask

  task automatic run(input string tag, input int n, input logic [PW-1:0] mask);
    for (int k = 0; k < n; k++) applyCycle(tag, 1'b0, 1'b0, 4'd0, 5'd0, rnd() & mask);
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [PW-1:0] p;
    logic [PW-1:0] all1;
    all1 = '1;
    qM = '0;
    for (int i = 0; i < NC; i++) cfgM[i] = '0;
    repeat (2) @(posedge clk);

    // R1: reset state with random terms
    run("R1", 4, ~srMask());

    // R3 / R12: bypass, every local pattern in every cell
    writeAll(5'b01000);
    for (int v = 0; v < 16; v++) begin
      p = '0;
      for (int i = 0; i < NC; i++) p[5*i +: 4] = 4'(v);
      applyCycle("R3", 1'b0, 1'b0, 4'd0, 5'd0, p);
    end
    run("R12", 32, all1);

    // R11: inverted bypass output
    writeAll(5'b01100);
    run("R11", 24, all1);

    // R2: unused addresses are ignored
    for (int a = NC; a < 16; a++) applyCycle("R2", 1'b0, 1'b1, 4'(a), 5'b11111, rnd());
    run("R2", 12, all1);

    // R6: full chain, walking single term
    writeAll(5'b01001);
    applyCycle("R6", 1'b0, 1'b1, 4'd8, 5'b01000, '0);
    applyCycle("R6", 1'b0, 1'b0, 4'd0, 5'd0, '0);
    for (int b = 0; b < PW; b++) applyCycle("R6", 1'b0, 1'b0, 4'd0, 5'd0, PW'(1) << b);

    // R4 / R5: random export patterns, combinational view
    for (int k = 0; k < 40; k++) begin
      for (int a = 0; a < NC; a++)
        applyCycle("R4", 1'b0, 1'b1, 4'(a), 5'($urandom()) | 5'b01000, rnd());
      run("R4", 6, all1);
      run("R5", 4, srMask());
    end

    // R7: export on last cell has no effect
    writeAll(5'b01000);
    applyCycle("R7", 1'b0, 1'b1, 4'd8, 5'b01001, rnd());
    run("R7", 20, all1);

    // R8: D mode registered
    writeAll(5'b00000);
    run("R8", 40, ~srMask());

    // R9: T mode registered
    writeAll(5'b00010);
    run("R9", 40, ~srMask());

    // R10: set/reset with mixed kinds and modes
    for (int k = 0; k < 10; k++) begin
      for (int a = 0; a < NC; a++)
        applyCycle("R10", 1'b0, 1'b1, 4'(a), 5'($urandom()) & 5'b10011, rnd());
      run("R10", 12, all1);
    end

    // R1: reset after a dirty configuration
    writeAll(5'b01101);
    run("R1", 4, all1);
    applyCycle("R1", 1'b1, 1'b0, 4'd0, 5'd0, rnd());
    run("R1", 3, ~srMask());

    // Mixed random traffic
    for (int k = 0; k < 3000; k++)
      applyCycle("R12", ($urandom() % 200) == 0, ($urandom() % 4) == 0,
                 4'($urandom()), 5'($urandom()), rnd());

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule